// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital input stage of a two-channel 12-bit voltage-output converter. A host shifts in one 16-bit word per chip-select window on a serial clock and data line. The first data bit must already be on the data line when chip select goes low, and there is no frame-sync pulse. The top four bits form a control nibble. The remaining twelve bits are the code, sent most significant bit first.

Two bits of the nibble pick the destination of the code: channel B alone, a shared holding buffer, or channel A. When channel A is the destination, channel B is loaded from the holding buffer in the same update, so both analog outputs can be changed together. The other two bits drive a speed-mode flag and a power-down flag. The serial pins are sampled in the `clk` domain. A word is acted on only when chip select rises after exactly sixteen serial clock falls.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `rst_n` is low, `code_a`, `code_b` and `hold_code` are zero, and `fast_mode` and `power_down` are 0.
- R2: While `cs_n` is low, `din` is captured on each falling edge of `sclk`, most significant bit first. In the 16-bit word, bit 15 is the select-high bit S1, bit 14 is the speed bit, bit 13 is the power bit, bit 12 is the select-low bit S0, and bits 11:0 are the code.
- R3: When {S1,S0} = 00, the code is written to `code_b`. `code_a` and `hold_code` keep their values.
- R4: When {S1,S0} = 01, the code is written to `hold_code` only. `code_a` and `code_b` keep their values.
- R5: When {S1,S0} = 10, the code is written to `code_a`, and in the same cycle `code_b` takes the value `hold_code` had before the update.
- R6: When {S1,S0} = 11, nothing changes. This includes both flags.
- R7: For every accepted non-reserved word, `fast_mode` takes the value of the speed bit (1 = fast, 0 = slow).
- R8: For every accepted non-reserved word, `power_down` takes the value of the power bit (1 = powered down, 0 = normal).
- R9: A frame in which `cs_n` rises after fewer than 16 falling `sclk` edges changes no output.
- R10: A frame in which `cs_n` rises after more than 16 falling `sclk` edges changes no output.
- R11: The outputs change only on the `clk` edge at which a rising `cs_n` is first seen. They do not change while `cs_n` stays low after the sixteenth bit.
- R12: `sclk` edges while `cs_n` is high shift nothing. The bit count restarts with every new frame, so an aborted frame does not affect the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| hold_code | output | 12 | Shared holding buffer |
| fast_mode | output | 1 | 1 = fast settling mode |
| power_down | output | 1 | 1 = powered down |

## Verification
The pins are registered once for edge detection, so a falling `sclk` takes effect at the first `clk` rise that sees it. A rising `cs_n` updates the outputs at the first `clk` rise that sees it, and the result can be read at the following falling `clk` edge. The bench changes inputs on falling `clk` edges and reads the outputs one falling edge after it raises `cs_n`. For R11 it also reads the outputs while `cs_n` is still held low after the sixteenth bit, to confirm that nothing has moved early. The R1 check is made during an asserted reset, before any clock edge could be involved.

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int CODE_W = 12,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              cs_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] hold_code,
  output logic              fast_mode,
  output logic              power_down
);
  localparam int WORD_W  = CODE_W + CTRL_W;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int S1_POS  = WORD_W - 1;
  localparam int SPD_POS = WORD_W - 2;
  localparam int PWR_POS = WORD_W - 3;
  localparam int S0_POS  = WORD_W - 4;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic              sclk_q, cs_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  wire sclk_fall = sclk_q & ~sclk & ~cs_n;
  wire cs_rise   = ~cs_q & cs_n;
  wire frame_ok  = cs_rise && (bit_cnt == CNT_FULL);
  wire [1:0] sel = {shreg[S1_POS], shreg[S0_POS]};
  wire [CODE_W-1:0] payload = shreg[CODE_W-1:0];

  wire wr_b = frame_ok && (sel == 2'b00);
  wire wr_h = frame_ok && (sel == 2'b01);
  wire wr_a = frame_ok && (sel == 2'b10);
  wire wr_f = frame_ok && (sel != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        shreg <= {shreg[WORD_W-2:0], din};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a     <= '0;
      code_b     <= '0;
      hold_code  <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
    end else begin
      if (wr_h) hold_code <= payload;
      if (wr_b) code_b <= payload;
      if (wr_a) begin
        code_a <= payload;
        code_b <= hold_code;
      end
      if (wr_f) begin
        fast_mode  <= shreg[SPD_POS];
        power_down <= shreg[PWR_POS];
      end
    end
  end

  assert_quiet_between_frames_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(code_a) && $stable(code_b) && $stable(hold_code)
                 && $stable(fast_mode) && $stable(power_down));

  assert_b_from_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && sel == 2'b10) |=> (code_b == $past(hold_code)) && $stable(hold_code));

  assert_buffer_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && sel == 2'b01) |=> $stable(code_a) && $stable(code_b));

  assert_reserved_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && sel == 2'b11) |=> $stable(code_a) && $stable(code_b) && $stable(hold_code)
                                   && $stable(fast_mode) && $stable(power_down));

  assert_short_frame_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt < CNT_FULL) |=> $stable(code_a) && $stable(code_b) && $stable(hold_code)
                                        && $stable(fast_mode) && $stable(power_down));

  assert_long_frame_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt > CNT_FULL) |=> $stable(code_a) && $stable(code_b) && $stable(hold_code)
                                        && $stable(fast_mode) && $stable(power_down));
endmodule

// File: tb/dual_dac_serial_if_bench.sv
module dual_dac_serial_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic cs_n = 1'b1;
  logic [11:0] code_a, code_b, hold_code;
  logic fast_mode, power_down;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_dac_serial_if u_dual_dac_serial_if (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n),
    .code_a(code_a), .code_b(code_b), .hold_code(hold_code),
    .fast_mode(fast_mode), .power_down(power_down)
  );

  localparam int NV = 10;
  localparam logic [15:0] VW [NV] = '{16'h1ABC, 16'h4123, 16'h8456, 16'h3FFF, 16'h9000,
                                      16'hF777, 16'hE001, 16'h0800, 16'h5555, 16'hAAAA};
  localparam logic [11:0] VA [NV] = '{12'h000, 12'h000, 12'h456, 12'h456, 12'h456,
                                      12'h456, 12'h001, 12'h001, 12'h001, 12'hAAA};
  localparam logic [11:0] VB [NV] = '{12'h000, 12'h123, 12'hABC, 12'hABC, 12'hABC,
                                      12'hABC, 12'hFFF, 12'h800, 12'h800, 12'h555};
  localparam logic [11:0] VH [NV] = '{12'hABC, 12'hABC, 12'hABC, 12'hFFF, 12'hFFF,
                                      12'hFFF, 12'hFFF, 12'hFFF, 12'h555, 12'h555};
  localparam logic VF [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic VP [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [11:0] a, input logic [11:0] b,
                         input logic [11:0] h, input logic f, input logic p);
    chk({req, " code_a"}, code_a, a);
    chk({req, " code_b"}, code_b, b);
    chk({req, " hold_code"}, hold_code, h);
    chk({req, " fast_mode"}, {11'd0, fast_mode}, {11'd0, f});
    chk({req, " power_down"}, {11'd0, power_down}, {11'd0, p});
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    shift_bits(bits, n);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_all("R1 reset", 12'h0, 12'h0, 12'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < NV; v++) begin
      frame({16'd0, VW[v]}, 16);
      chk_all($sformatf("R2-vector%0d R3/R4/R5/R6/R7/R8", v), VA[v], VB[v], VH[v], VF[v], VP[v]);
    end

    // R9: 15-bit frame, B write with speed set
    frame({17'd0, 15'h2123}, 15);
    chk_all("R9 short frame", 12'hAAA, 12'h555, 12'h555, 1'b0, 1'b1);

    // R10: 17-bit frame
    frame({15'd0, 17'h04321}, 17);
    chk_all("R10 long frame", 12'hAAA, 12'h555, 12'h555, 1'b0, 1'b1);

    // R12: sclk toggles with cs_n high, then an aborted frame, then a valid frame
    shift_bits(32'h0000_FFFF, 8);
    chk_all("R12 idle clocks", 12'hAAA, 12'h555, 12'h555, 1'b0, 1'b1);
    frame(32'h0000_00FF, 7);
    frame(32'h0000_4321, 16);
    chk_all("R12 restart R3", 12'hAAA, 12'h321, 12'h555, 1'b1, 1'b0);

    // R11: outputs hold until cs_n rises
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    shift_bits(32'h0000_8F0F, 16);
    repeat (6) @(negedge clk);
    chk_all("R11 before cs rise", 12'hAAA, 12'h321, 12'h555, 1'b1, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    chk_all("R11 after cs rise R5", 12'hF0F, 12'h555, 12'h555, 1'b0, 1'b0);

    // R1: reset during operation
    rst_n = 1'b0;
    #1;
    chk_all("R1 mid reset", 12'h0, 12'h0, 12'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule